// File: doc/BRIEF.md
# Eight-Line Interrupt Controller Command Decoder

This block is the programming front end of an eight-line priority interrupt controller. Software reaches it through a byte-wide port with a one-bit address. Writes at address 0 either start the initialization sequence or carry an operational command. Writes at address 1 either load the mask or supply the next initialization word. The block holds the mask, the vector base, the rotating priority base and the mode bits. It drives one-cycle clear pulses toward the in-service and request registers, which live in the neighbouring resolver and capture logic.

After the start word, an initialization walk takes the vector base. It then takes an optional cascade word and an optional fourth word, and which of these apply depends on two bits latched from the start word. Operational commands select which register a read at address 0 returns, arm a poll, load special mask, and issue eight end-of-interrupt and rotation codes. A read after a poll command returns the winning line and acknowledges it. Strobes last one clock, and read data appears on the clock after the read strobe.

Top module: `intc_cmd_decode`

## Requirements
- R1: After reset, the mask, vector base, priority base, fully-nested, auto-EOI, rotate-on-auto-EOI and special-mask outputs are all zero, the clear pulses are zero, and the sequencer is idle, so that a write at address 1 loads the mask.
- R2: A write at address 0 with bit 4 set is a start word. On the next clock the mask, vector base, priority base and every mode bit are cleared, read-select and the poll flag are cleared, and both clear pulses equal 8'hFF for one cycle. The sequencer then expects the vector base.
- R3: The first write at address 1 after a start word sets the vector base to the written byte ANDed with 8'hF8, and it leaves the mask unchanged.
- R4: Start-word bit 1 (single) and bit 0 (fourth word needed) set the walk. When single is 0, one further address-1 write is consumed as the cascade word. The fourth word follows only when its bit was set. In every case the sequencer then returns to idle.
- R5: In the fourth word, bit 4 sets the fully-nested output and bit 1 sets the auto-EOI output. The mask is not loaded.
- R6: A write at address 1 loads the mask only while the sequencer is idle.
- R7: A write at address 0 with bit 4 clear and bit 3 set is a read command. Bit 2 arms poll. Bit 1 allows read-select to take bit 0. Bit 6 allows special mask to take bit 5. With an enable bit clear, the matching state is unchanged.
- R8: A read without a pending poll returns, one clock later, the mask at address 1. At address 0 it returns the in-service input when read-select is 1 and the request input when read-select is 0. Such a read issues no clear pulse.
- R9: A write at address 0 with bits 4 and 3 clear is a command coded in bits 7:5. Code 0 clears rotate-on-auto-EOI and code 4 sets it.
- R10: Priority rank k belongs to line (k + priority base) mod 8, and rank 0 is highest. Code 1 pulses the in-service clear for the highest-ranked set in-service bit, or nothing when none is set. Code 5 does the same and also sets the priority base to that line + 1 mod 8.
- R11: With L = data bits 2:0: code 3 pulses the in-service clear for line L, code 6 sets the priority base to L + 1 mod 8, and code 7 does both. Code 2 has no effect.
- R12: The first read after poll is armed returns 8'h80 | line for the highest-ranked unmasked request, when that request ranks strictly above the highest-ranked in-service bit. When special mask is 1, masked in-service bits are ignored in that comparison. The read also pulses both clears for that line. Otherwise the read returns 8'h00 and pulses nothing. The poll flag then clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register address |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| wdata | input | 8 | Write data |
| req_in | input | 8 | Request register from capture logic |
| isr_in | input | 8 | In-service register from resolver |
| rdata | output | 8 | Read data, valid the clock after rd_en |
| mask | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| prio_base | output | 3 | Line currently holding top priority |
| fully_nested | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| rotate_aeoi | output | 1 | Rotate on automatic end of interrupt |
| special_mask | output | 1 | Special mask mode |
| isr_clr | output | 8 | One-cycle in-service clear pulses |
| req_clr | output | 8 | One-cycle request clear pulses |

## Verification
If the sequencer is in the wrong step, the next address-1 write lands in the wrong register, and the mask or vector base port shows it one clock later. A wrong priority base or special-mask bit is hidden until an end-of-interrupt or poll happens. Because of that, the sweeps run every in-service pattern against every base, and poll against many request and mask patterns. A rotation error then shows as a wrong one-hot clear pulse or poll byte on the clock after the strobe. A poll flag that stays armed shows on the following ordinary read.

// File: rtl/intc_cmd_decode.sv
module intc_cmd_decode #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] req_in,
  input  logic [DW-1:0] isr_in,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] vec_base,
  output logic [2:0]    prio_base,
  output logic          fully_nested,
  output logic          auto_eoi,
  output logic          rotate_aeoi,
  output logic          special_mask,
  output logic [DW-1:0] isr_clr,
  output logic [DW-1:0] req_clr
);
  typedef enum logic [1:0] {ST_IDLE, ST_VEC, ST_CAS, ST_FOURTH} step_t;

  step_t step;
  logic  single, need4, rsel, poll;

  function automatic logic [3:0] rank(input logic [7:0] m, input logic [2:0] b);
    logic [3:0] r;
    r = 4'd8;
    for (int k = 7; k >= 0; k--)
      if (m[3'(k) + b]) r = 4'(k);
    return r;
  endfunction

  wire       wr0  = wr_en && !addr;
  wire       wr1  = wr_en && addr;
  wire       icw1 = wr0 && wdata[4];
  wire       ocw3 = wr0 && !wdata[4] && wdata[3];
  wire       ocw2 = wr0 && !wdata[4] && !wdata[3];
  wire [2:0] code = wdata[7:5];
  wire [2:0] lvl  = wdata[2:0];

  wire [7:0] cur_set  = special_mask ? (isr_in & ~mask) : isr_in;
  wire [3:0] req_rank = rank(req_in & ~mask, prio_base);
  wire [3:0] cur_rank = rank(cur_set, prio_base);
  wire       win      = req_rank < cur_rank;
  wire [2:0] win_line = req_rank[2:0] + prio_base;
  wire [3:0] top_rank = rank(isr_in, prio_base);
  wire       isr_any  = !top_rank[3];
  wire [2:0] top_line = top_rank[2:0] + prio_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step         <= ST_IDLE;
      single       <= 1'b0;
      need4        <= 1'b0;
      rsel         <= 1'b0;
      poll         <= 1'b0;
      mask         <= '0;
      vec_base     <= '0;
      prio_base    <= '0;
      fully_nested <= 1'b0;
      auto_eoi     <= 1'b0;
      rotate_aeoi  <= 1'b0;
      special_mask <= 1'b0;
      rdata        <= '0;
      isr_clr      <= '0;
      req_clr      <= '0;
    end else begin
      isr_clr <= '0;
      req_clr <= '0;
      if (icw1) begin
        step         <= ST_VEC;
        single       <= wdata[1];
        need4        <= wdata[0];
        rsel         <= 1'b0;
        poll         <= 1'b0;
        mask         <= '0;
        vec_base     <= '0;
        prio_base    <= '0;
        fully_nested <= 1'b0;
        auto_eoi     <= 1'b0;
        rotate_aeoi  <= 1'b0;
        special_mask <= 1'b0;
        isr_clr      <= '1;
        req_clr      <= '1;
      end else if (wr1) begin
        case (step)
          ST_IDLE: mask <= wdata;
          ST_VEC: begin
            vec_base <= wdata & 8'hF8;
            if (!single)    step <= ST_CAS;
            else if (need4) step <= ST_FOURTH;
            else            step <= ST_IDLE;
          end
          ST_CAS: step <= need4 ? ST_FOURTH : ST_IDLE;
          default: begin
            fully_nested <= wdata[4];
            auto_eoi     <= wdata[1];
            step         <= ST_IDLE;
          end
        endcase
      end else if (ocw3) begin
        if (wdata[2]) poll <= 1'b1;
        if (wdata[1]) rsel <= wdata[0];
        if (wdata[6]) special_mask <= wdata[5];
      end else if (ocw2) begin
        case (code)
          3'd0, 3'd4: rotate_aeoi <= code[2];
          3'd1: if (isr_any) isr_clr <= 8'b1 << top_line;
          3'd5: if (isr_any) begin
            isr_clr   <= 8'b1 << top_line;
            prio_base <= top_line + 3'd1;
          end
          3'd3: isr_clr <= 8'b1 << lvl;
          3'd6: prio_base <= lvl + 3'd1;
          3'd7: begin
            isr_clr   <= 8'b1 << lvl;
            prio_base <= lvl + 3'd1;
          end
          default: ;
        endcase
      end
      if (rd_en) begin
        if (poll) begin
          poll <= 1'b0;
          if (win) begin
            rdata   <= {5'b10000, win_line};
            isr_clr <= 8'b1 << win_line;
            req_clr <= 8'b1 << win_line;
          end else begin
            rdata <= '0;
          end
        end else begin
          rdata <= addr ? mask : (rsel ? isr_in : req_in);
        end
      end
    end
  end

  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_CAS) |-> !single); // R4
  AST_MASK_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask) |-> ($past(icw1) || ($past(wr1) && $past(step) == ST_IDLE))); // R6
  AST_POLL_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && poll) |-> (rdata[6:3] == 4'd0 && (rdata[7] || rdata == 8'd0))); // R12
  AST_QUIET_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en) && !$past(poll) && !$past(wr_en)) |-> (isr_clr == 8'd0 && req_clr == 8'd0)); // R8
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(icw1) |-> $onehot0(isr_clr)); // R10
endmodule

// File: tb/intc_cmd_decode_tb.sv
`timescale 1ns/1ps
module intc_cmd_decode_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, req_in = '0, isr_in = '0;
  logic [7:0] rdata, mask, vec_base, isr_clr, req_clr;
  logic [2:0] prio_base;
  logic       fully_nested, auto_eoi, rotate_aeoi, special_mask;
  int vecs = 0, errs = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intc_cmd_decode u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .req_in(req_in), .isr_in(isr_in), .rdata(rdata),
    .mask(mask), .vec_base(vec_base), .prio_base(prio_base),
    .fully_nested(fully_nested), .auto_eoi(auto_eoi), .rotate_aeoi(rotate_aeoi),
    .special_mask(special_mask), .isr_clr(isr_clr), .req_clr(req_clr)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic int rk(input logic [7:0] m, input int b);
    for (int k = 0; k < 8; k++) if (m[(k + b) % 8]) return k;
    return 8;
  endfunction

  task automatic init_seq(input logic [7:0] w1, input int casc, input int fourth);
    wr(0, w1);
    wr(1, 8'h5F);
    chk("R3 vector base", vec_base, 8'h58);
    chk("R3 mask untouched", mask, 8'h00);
    if (casc) begin wr(1, 8'h77); chk("R4 cascade word not mask", mask, 8'h00); end
    if (fourth) begin
      wr(1, 8'h12);
      chk("R5 fourth word modes", {6'd0, fully_nested, auto_eoi}, 8'h03);
      chk("R5 mask untouched", mask, 8'h00);
    end
    wr(1, 8'h3C);
    chk("R4 idle after walk R6", mask, 8'h3C);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mask", mask, 0); chk("R1 vec", vec_base, 0); chk("R1 prio", {5'd0, prio_base}, 0);
    chk("R1 modes", {4'd0, fully_nested, auto_eoi, rotate_aeoi, special_mask}, 0);
    chk("R1 clears", isr_clr | req_clr, 0);
    wr(1, 8'hA5); chk("R1 R6 idle mask load", mask, 8'hA5);

    wr(0, 8'h68); wr(0, 8'h80); wr(0, 8'hC3);
    wr(0, 8'h13);
    chk("R2 isr_clr pulse", isr_clr, 8'hFF); chk("R2 req_clr pulse", req_clr, 8'hFF);
    chk("R2 mask cleared", mask, 0); chk("R2 prio cleared", {5'd0, prio_base}, 0);
    chk("R2 modes cleared", {6'd0, rotate_aeoi, special_mask}, 0);
    @(negedge clk); chk("R2 pulse one cycle", isr_clr, 0);
    wr(1, 8'h5F); chk("R3 vector", vec_base, 8'h58);
    wr(1, 8'h12); chk("R5 modes", {6'd0, fully_nested, auto_eoi}, 8'h03);
    wr(1, 8'h3C); chk("R6 idle again", mask, 8'h3C);

    init_seq(8'h10, 1, 0);
    init_seq(8'h11, 1, 1);
    init_seq(8'h12, 0, 0);
    init_seq(8'h13, 0, 1);

    req_in = 8'h5A; isr_in = 8'hC3; wr(1, 8'h81);
    rd(0); chk("R8 default reads request", rdata, 8'h5A);
    rd(1); chk("R8 address 1 reads mask", rdata, 8'h81);
    chk("R8 no clear on plain read", isr_clr | req_clr, 0);
    wr(0, 8'h0B); rd(0); chk("R7 R8 select in-service", rdata, 8'hC3);
    wr(0, 8'h09); rd(0); chk("R7 select held when bit1 clear", rdata, 8'hC3);
    wr(0, 8'h0A); rd(0); chk("R7 select request", rdata, 8'h5A);
    wr(0, 8'h28); chk("R7 special mask ignored bit6 clear", {7'd0, special_mask}, 0);
    wr(0, 8'h68); chk("R7 special mask set", {7'd0, special_mask}, 1);
    wr(0, 8'h48); chk("R7 special mask cleared", {7'd0, special_mask}, 0);

    wr(0, 8'h80); chk("R9 code 4 sets rotate", {7'd0, rotate_aeoi}, 1);
    wr(0, 8'h00); chk("R9 code 0 clears rotate", {7'd0, rotate_aeoi}, 0);
    wr(0, 8'h65); chk("R11 code 3 clear", isr_clr, 8'h20);
    wr(0, 8'hC2); chk("R11 code 6 base", {5'd0, prio_base}, 3);
    wr(0, 8'hE7); chk("R11 code 7 clear", isr_clr, 8'h80);
    chk("R11 code 7 base wraps", {5'd0, prio_base}, 0);
    wr(0, 8'h44); chk("R11 code 2 no effect", {5'd0, prio_base} | isr_clr, 0);

    wr(1, 8'h00); req_in = 8'h04; isr_in = 8'h00;
    wr(0, 8'h0C); rd(1);
    chk("R12 poll line", rdata, 8'h82);
    rd(1); chk("R12 poll cleared after one read", rdata, 8'h00);

    for (int b = 0; b < 8; b++)
      for (int v = 0; v < 256; v++) begin
        int t;
        logic [7:0] e;
        wr(0, 8'hC0 | 8'((b + 7) % 8));
        isr_in = 8'(v);
        t = rk(8'(v), b);
        e = (t == 8) ? 8'h00 : 8'(1 << ((t + b) % 8));
        wr(0, 8'h20); chk("R10 code 1 clear", isr_clr, e);
        wr(0, 8'hA0); chk("R10 code 5 clear", isr_clr, e);
        chk("R10 code 5 base", {5'd0, prio_base}, (t == 8) ? 8'(b) : 8'((t + b + 1) % 8));
      end

    for (int b = 0; b < 8; b++)
      for (int ri = 0; ri < 16; ri++)
        for (int vi = 0; vi < 6; vi++)
          for (int sm = 0; sm < 2; sm++) begin
            logic [7:0] r, v, mk, cm, e, c;
            int rp, cp;
            r  = 8'((ri * 29 + b) % 256);
            v  = (vi == 0) ? 8'h00 : (vi == 1) ? 8'h01 : (vi == 2) ? 8'h10 :
                 (vi == 3) ? 8'h81 : (vi == 4) ? 8'h24 : 8'hFF;
            mk = 8'((ri * 7) ^ (vi * 19)) & 8'hB6;
            wr(0, 8'hC0 | 8'((b + 7) % 8));
            wr(1, mk);
            wr(0, (sm != 0) ? 8'h68 : 8'h48);
            req_in = r; isr_in = v;
            cm = (sm != 0) ? (v & ~mk) : v;
            rp = rk(r & ~mk, b);
            cp = rk(cm, b);
            if (rp < cp) begin
              e = 8'h80 | 8'((rp + b) % 8);
              c = 8'(1 << ((rp + b) % 8));
            end else begin
              e = 8'h00; c = 8'h00;
            end
            wr(0, 8'h0C); rd(0);
            chk("R12 poll byte", rdata, e);
            chk("R12 poll isr clear", isr_clr, c);
            chk("R12 poll req clear", req_clr, c);
          end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule